// File: doc/BRIEF.md
# I2C 10-bit Slave Address Matcher

This block sits beside an I2C slave byte receiver and decides, one address byte at a time, whether the device is the target of a 10-bit addressed transfer. The receiver reports bus events (START, repeated START, STOP) as one-cycle pulses. It also presents each received byte together with a one-cycle valid strobe. The matcher answers with acknowledge requests that the receiver turns into ACK bits on the bus. It also keeps an "addressed" flag and a read/write direction flag that the data-phase logic uses.

A 10-bit address arrives as two bytes. The header byte carries the reserved pattern 11110 in bits 7..3, the two upper address bits in bits 2..1 and the direction in bit 0 (0 = master writes). The second byte carries the lower eight address bits. Both bytes must match before the device counts as addressed. Once addressed, the device stays addressed through any number of data bytes. It leaves that state on a STOP, or on a repeated START followed by a header for another device. While addressed, a repeated START with a matching header and bit 0 = 1 turns the transfer into a read without a second address byte.

All outputs are registered. An acknowledge request appears in the clock cycle right after the valid strobe of the byte that earned it.

Top module: `i2c10_addr_match`

## Requirements
- R1: After reset, ack_hdr_o, ack_low_o, addressed_o and read_o are all 0.
- R2: After a START, a byte whose bits 7..3 are 11110, whose bits 2..1 equal own_addr_i[9:8] and whose bit 0 is 0 raises ack_hdr_o in the cycle after its valid strobe.
- R3: After a START, a header byte with a wrong prefix, wrong upper bits or bit 0 = 1 gets no acknowledge. No later byte is acknowledged until the next START.
- R4: Once the header is acknowledged, a second byte equal to own_addr_i[7:0] raises ack_low_o in the cycle after its strobe. From that cycle on, addressed_o = 1 and read_o = 0.
- R5: Once the header is acknowledged, a second byte different from own_addr_i[7:0] gets no acknowledge and leaves addressed_o at 0. No later byte is acknowledged until the next START.
- R6: While addressed, data bytes get no acknowledge request and addressed_o stays 1.
- R7: A STOP clears addressed_o and read_o in the following cycle.
- R8: While addressed, a repeated START keeps addressed_o at 1. A following matching header with bit 0 = 1 raises ack_hdr_o and sets read_o = 1, with addressed_o still 1.
- R9: While addressed, a repeated START followed by a header that does not match clears addressed_o and gets no acknowledge.
- R10: Each acknowledge request is a one-cycle pulse. A byte strobe in the same cycle as a START, repeated START or STOP is ignored.
- R11: While addressed, a repeated START followed by a matching header with bit 0 = 0 raises ack_hdr_o and clears addressed_o. A matching second byte then has to acknowledge and address the device again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | START detected (one-cycle pulse) |
| rstart_i | input | 1 | Repeated START detected (one-cycle pulse) |
| stop_i | input | 1 | STOP detected (one-cycle pulse) |
| byte_i | input | 8 | Received byte |
| byte_vld_i | input | 1 | byte_i is valid this cycle |
| own_addr_i | input | 10 | Configured own 10-bit address |
| ack_hdr_o | output | 1 | Request ACK for the header byte |
| ack_low_o | output | 1 | Request ACK for the low address byte |
| addressed_o | output | 1 | Device is the addressed slave |
| read_o | output | 1 | Addressed transfer is a master read |

## Verification
A wrong sequencer state shows up at the latest on the next byte strobe. It appears as an acknowledge pulse where none belongs or a missing one, one cycle after that strobe. A state that is skipped or kept too long changes addressed_o or read_o on the cycle after the bus event or byte that should have moved it. The directed scenarios therefore check every output in that cycle and again one cycle later, so that both wrong transitions and stretched pulses are caught.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int PFX_W  = 5;
  localparam logic [PFX_W-1:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,   // no transfer of interest
    ST_HDR,    // expect header byte after START
    ST_LOW,    // header accepted, expect low address byte
    ST_WR,     // addressed, master writing
    ST_RD,     // addressed, master reading
    ST_SKIP,   // not for us until next START
    ST_REHDR   // addressed, repeated START seen, expect header
  } seq_st_t;

  typedef struct packed {
    logic hi_ok;  // prefix and upper bits match
    logic rd;     // direction bit
  } hdr_res_t;
endpackage

// File: rtl/i2c10_hdr_cmp.sv
module i2c10_hdr_cmp
  import i2c10_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic [BW-1:0] byte_i,
  input  logic [AW-1:0] own_i,
  output hdr_res_t      res_o
);
  localparam int HI_W = AW - BW;

  logic pfx_ok;
  logic hi_ok;

  assign pfx_ok    = (byte_i[BW-1 -: PFX_W] == HDR_PREFIX);
  assign hi_ok     = (byte_i[HI_W:1] == own_i[AW-1 -: HI_W]);
  assign res_o.hi_ok = pfx_ok && hi_ok;
  assign res_o.rd    = byte_i[0];
endmodule

// File: rtl/i2c10_low_cmp.sv
module i2c10_low_cmp
  import i2c10_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic [BW-1:0] byte_i,
  input  logic [AW-1:0] own_i,
  output logic          eq_o
);
  logic [BW-1:0] diff;

  genvar g;
  generate
    for (g = 0; g < BW; g++) begin : g_bit
      assign diff[g] = byte_i[g] ^ own_i[g];
    end
  endgenerate

  assign eq_o = (diff == '0);
endmodule

// File: rtl/i2c10_seq.sv
module i2c10_seq
  import i2c10_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start_i,
  input  logic     rstart_i,
  input  logic     stop_i,
  input  logic     vld_i,
  input  hdr_res_t hdr_i,
  input  logic     low_eq_i,
  output logic     ack_hdr_o,
  output logic     ack_low_o,
  output logic     addressed_o,
  output logic     read_o
);
  seq_st_t st_q, st_d;
  logic ack_hdr_d, ack_low_d, addr_d, rd_d;

  always_comb begin
    st_d      = st_q;
    ack_hdr_d = 1'b0;
    ack_low_d = 1'b0;
    addr_d    = addressed_o;
    rd_d      = read_o;
    if (stop_i) begin
      st_d   = ST_IDLE;
      addr_d = 1'b0;
      rd_d   = 1'b0;
    end else if (start_i) begin
      st_d   = ST_HDR;
      addr_d = 1'b0;
      rd_d   = 1'b0;
    end else if (rstart_i) begin
      if (addressed_o) begin
        st_d = ST_REHDR;
      end else begin
        st_d = ST_HDR;
        rd_d = 1'b0;
      end
    end else if (vld_i) begin
      unique case (st_q)
        ST_HDR: begin
          if (hdr_i.hi_ok && !hdr_i.rd) begin
            st_d      = ST_LOW;
            ack_hdr_d = 1'b1;
          end else begin
            st_d = ST_SKIP;
          end
        end
        ST_LOW: begin
          if (low_eq_i) begin
            st_d      = ST_WR;
            ack_low_d = 1'b1;
            addr_d    = 1'b1;
            rd_d      = 1'b0;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_REHDR: begin
          if (!hdr_i.hi_ok) begin
            st_d   = ST_SKIP;
            addr_d = 1'b0;
            rd_d   = 1'b0;
          end else if (hdr_i.rd) begin
            st_d      = ST_RD;
            ack_hdr_d = 1'b1;
            addr_d    = 1'b1;
            rd_d      = 1'b1;
          end else begin
            st_d      = ST_LOW;
            ack_hdr_d = 1'b1;
            addr_d    = 1'b0;
            rd_d      = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      ack_hdr_o   <= 1'b0;
      ack_low_o   <= 1'b0;
      addressed_o <= 1'b0;
      read_o      <= 1'b0;
    end else begin
      st_q        <= st_d;
      ack_hdr_o   <= ack_hdr_d;
      ack_low_o   <= ack_low_d;
      addressed_o <= addr_d;
      read_o      <= rd_d;
    end
  end
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
  import i2c10_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          rstart_i,
  input  logic          stop_i,
  input  logic [BW-1:0] byte_i,
  input  logic          byte_vld_i,
  input  logic [AW-1:0] own_addr_i,
  output logic          ack_hdr_o,
  output logic          ack_low_o,
  output logic          addressed_o,
  output logic          read_o
);
  hdr_res_t hdr_res;
  logic     low_eq;

  i2c10_hdr_cmp #(.BW(BW), .AW(AW)) hdr_cmp_i (
    .byte_i (byte_i),
    .own_i  (own_addr_i),
    .res_o  (hdr_res)
  );

  i2c10_low_cmp #(.BW(BW), .AW(AW)) low_cmp_i (
    .byte_i (byte_i),
    .own_i  (own_addr_i),
    .eq_o   (low_eq)
  );

  i2c10_seq seq_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rstart_i    (rstart_i),
    .stop_i      (stop_i),
    .vld_i       (byte_vld_i),
    .hdr_i       (hdr_res),
    .low_eq_i    (low_eq),
    .ack_hdr_o   (ack_hdr_o),
    .ack_low_o   (ack_low_o),
    .addressed_o (addressed_o),
    .read_o      (read_o)
  );
endmodule

// File: rtl/i2c10_addr_match_chk.sv
module i2c10_addr_match_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic rstart_i,
  input logic stop_i,
  input logic byte_vld_i,
  input logic ack_hdr_o,
  input logic ack_low_o,
  input logic addressed_o,
  input logic read_o
);
  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    (ack_hdr_o || ack_low_o) |-> $past(byte_vld_i) && !$past(start_i || rstart_i || stop_i)); // R10
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack_hdr_o |=> !ack_hdr_o); // R10
  AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ack_hdr_o && ack_low_o)); // R4
  AST_LOW_ACK_ADDRESSES: assert property (@(posedge clk) disable iff (rst)
    ack_low_o |-> addressed_o && !read_o); // R4
  AST_READ_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    read_o |-> addressed_o); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    $past(stop_i) |-> !addressed_o && !read_o); // R7
  AST_ADDR_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    (addressed_o && !byte_vld_i && !start_i && !rstart_i && !stop_i) |=> addressed_o); // R6
endmodule

bind i2c10_addr_match i2c10_addr_match_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .rstart_i    (rstart_i),
  .stop_i      (stop_i),
  .byte_vld_i  (byte_vld_i),
  .ack_hdr_o   (ack_hdr_o),
  .ack_low_o   (ack_low_o),
  .addressed_o (addressed_o),
  .read_o      (read_o)
);

// File: tb/i2c10_addr_match_tb_top.sv
module i2c10_addr_match_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, rstart_i = 1'b0, stop_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_vld_i = 1'b0;
  logic [9:0] own_addr_i = 10'h2A5;
  logic       ack_hdr_o, ack_low_o, addressed_o, read_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // own address 0x2A5: upper bits 10, low byte A5
  localparam logic [7:0] HDR_W  = 8'hF4; // 11110_10_0
  localparam logic [7:0] HDR_R  = 8'hF5; // 11110_10_1
  localparam logic [7:0] HDR_BAD = 8'hF6; // 11110_11_0
  localparam logic [7:0] PFX_BAD = 8'hE4; // 11100_10_0
  localparam logic [7:0] LOW_OK = 8'hA5;
  localparam logic [7:0] LOW_BAD = 8'hA4;

  always #5 clk = ~clk;

  i2c10_addr_match dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .rstart_i(rstart_i), .stop_i(stop_i),
    .byte_i(byte_i), .byte_vld_i(byte_vld_i), .own_addr_i(own_addr_i),
    .ack_hdr_o(ack_hdr_o), .ack_low_o(ack_low_o),
    .addressed_o(addressed_o), .read_o(read_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus; on return the registered result is visible.
  task automatic cyc(input bit s, input bit rs, input bit p, input bit v, input logic [7:0] b);
    @(negedge clk);
    start_i = s; rstart_i = rs; stop_i = p; byte_vld_i = v; byte_i = b;
    @(negedge clk);
    start_i = 1'b0; rstart_i = 1'b0; stop_i = 1'b0; byte_vld_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, b);
  endtask

  task automatic expect_out(input string req, input bit a1, input bit a2, input bit ad, input bit rd);
    check(req, "ack_hdr", int'(ack_hdr_o), int'(a1));
    check(req, "ack_low", int'(ack_low_o), int'(a2));
    check(req, "addressed", int'(addressed_o), int'(ad));
    check(req, "read", int'(read_o), int'(rd));
  endtask

  task automatic get_addressed();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    send(HDR_W);
    send(LOW_OK);
    expect_out("R4", 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    expect_out("R1", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_write();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    send(HDR_W);
    expect_out("R2", 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R10", "ack_hdr pulse end", int'(ack_hdr_o), 0);
    send(LOW_OK);
    expect_out("R4", 1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R10", "ack_low pulse end", int'(ack_low_o), 0);
    send(HDR_W);
    expect_out("R6", 1'b0, 1'b0, 1'b1, 1'b0);
    send(LOW_OK);
    expect_out("R6", 1'b0, 1'b0, 1'b1, 1'b0);
    send(8'h3C);
    expect_out("R6", 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_out("R7", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_hdr_mismatch();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    send(HDR_BAD);
    expect_out("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    send(LOW_OK);
    expect_out("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    send(HDR_W);
    expect_out("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    send(PFX_BAD);
    expect_out("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    send(HDR_R);
    expect_out("R3", 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_low_mismatch();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    send(HDR_W);
    expect_out("R2", 1'b1, 1'b0, 1'b0, 1'b0);
    send(LOW_BAD);
    expect_out("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    send(LOW_OK);
    expect_out("R5", 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_rstart_read();
    get_addressed();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    expect_out("R8", 1'b0, 1'b0, 1'b1, 1'b0);
    send(HDR_R);
    expect_out("R8", 1'b1, 1'b0, 1'b1, 1'b1);
    send(8'h5A);
    expect_out("R8", 1'b0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_out("R7", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rstart_other();
    get_addressed();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    send(HDR_BAD);
    expect_out("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    send(LOW_OK);
    expect_out("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_rstart_write();
    get_addressed();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    send(HDR_W);
    expect_out("R11", 1'b1, 1'b0, 1'b0, 1'b0);
    send(LOW_OK);
    expect_out("R11", 1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_collide();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, HDR_W);
    expect_out("R10", 1'b0, 1'b0, 1'b0, 1'b0);
    send(HDR_W);
    expect_out("R10", 1'b1, 1'b0, 1'b0, 1'b0);
    send(LOW_OK);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'h11);
    expect_out("R10", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_hdr_mismatch();
    t_low_mismatch();
    t_rstart_read();
    t_rstart_other();
    t_rstart_write();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule